// File: doc/BRIEF.md
# Cascaded Bus Clock Prescaler Chain

This block sits inside a clock controller and turns one fast system clock into four clock-enable strobes. Each strobe is one system-clock cycle wide. A main bus enable is divided down from the system clock. Two peripheral bus enables are each divided down from the main bus enable. A converter enable is divided down from the second peripheral bus enable. Logic in each derived domain stays on the system clock and advances only on cycles where its strobe is high.

A 16-bit configuration word sets all four stages, each from its own fixed field. Each stage also reports the divide ratio it is currently applying, so software can compute the resulting frequencies. A stage that receives a new code finishes its running period at the old ratio. The new ratio starts at the next terminal count, so no derived enable ever gets a shortened period.

Top module: `clk_prescale_chain`

## Requirements
- R1: The main stage takes its code from cfg_word[7:4]. A code with bit 3 clear selects divide-by-1. Codes 4'b1000 through 4'b1111 select 2, 4, 8, 16, 64, 128, 256 and 512, in that order. main_en is high once every ratio cycles, and main_div reports that ratio.
- R2: The first peripheral stage takes its code from cfg_word[10:8]. A code with bit 2 clear selects 1. Codes 3'b100 through 3'b111 select 2, 4, 8 and 16. The stage counts main_en pulses, so per1_en has a period of main ratio times per1 ratio, and per1_div reports the per1 ratio.
- R3: The second peripheral stage takes its code from cfg_word[13:11], with the same encoding as R2. It also counts main_en pulses, and per2_div reports its ratio.
- R4: The converter stage takes its code from cfg_word[15:14]. Codes 0, 1, 2 and 3 select 2, 4, 6 and 8. It counts per2_en pulses. conv_en is therefore never high on two consecutive cycles.
- R5: per1_en and per2_en are high only on cycles where main_en is high. conv_en is high only on cycles where per2_en is high.
- R6: A changed code takes effect only after the stage's current period ends. The reported ratio holds its old value until that stage's next strobe. The first period after the change runs at the old length.
- R7: Changing one field of cfg_word leaves the ratios and periods of the other stages unchanged.
- R8: After reset, with cfg_word all zero, main_en, per1_en and per2_en are high on every cycle. conv_en is high on every second cycle. The reported ratios are 1, 1, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 16 | Packed divide codes for all four stages |
| main_en | output | 1 | Main bus clock-enable strobe |
| per1_en | output | 1 | First peripheral bus clock-enable strobe |
| per2_en | output | 1 | Second peripheral bus clock-enable strobe |
| conv_en | output | 1 | Converter clock-enable strobe |
| main_div | output | 10 | Active main stage ratio |
| per1_div | output | 5 | Active first peripheral ratio |
| per2_div | output | 5 | Active second peripheral ratio |
| conv_div | output | 4 | Active converter ratio |

## Verification
The hardest situation to reach from the ports is a code change that lands in the middle of a long period, where a careless design would emit a runt strobe. The stimulus sets the main stage to divide-by-512 and waits for a main strobe. Ten cycles later it switches the main stage to divide-by-2. It then measures that the next gap is still 512 cycles, that the gap after it is 2, and that main_div held 512 until the boundary. Periods are measured as strobe-to-strobe gaps only after enough converter strobes have passed that every upstream stage has crossed a terminal count.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

  localparam int MAIN_W = 10;
  localparam int PER_W  = 5;
  localparam int CONV_W = 4;

  localparam int MAIN_LSB = 4;
  localparam int PER1_LSB = 8;
  localparam int PER2_LSB = 11;
  localparam int CONV_LSB = 14;

  // main stage: bit3 clear -> 1; otherwise power of two, skipping 32
  function automatic logic [MAIN_W-1:0] main_ratio(input logic [3:0] code);
    logic [3:0] sh;
    if (!code[3]) return MAIN_W'(1);
    sh = {1'b0, code[2:0]} + 4'd1 + {3'b0, code[2]};
    return MAIN_W'(1) << sh;
  endfunction

  // peripheral stage: bit2 clear -> 1; otherwise 2,4,8,16
  function automatic logic [PER_W-1:0] per_ratio(input logic [2:0] code);
    if (!code[2]) return PER_W'(1);
    return PER_W'(1) << ({1'b0, code[1:0]} + 3'd1);
  endfunction

  // converter stage: 2*(code+1)
  function automatic logic [CONV_W-1:0] conv_ratio(input logic [1:0] code);
    return {1'b0, ({1'b0, code} + 3'd1), 1'b0};
  endfunction

endpackage

// File: rtl/prescale_decode.sv
module prescale_decode
  import prescale_pkg::*;
(
  input  logic [15:0]       cfg,
  output logic [MAIN_W-1:0] main_r,
  output logic [PER_W-1:0]  per1_r,
  output logic [PER_W-1:0]  per2_r,
  output logic [CONV_W-1:0] conv_r
);
  always_comb begin
    main_r = main_ratio(cfg[MAIN_LSB +: 4]);
    per1_r = per_ratio(cfg[PER1_LSB +: 3]);
    per2_r = per_ratio(cfg[PER2_LSB +: 3]);
    conv_r = conv_ratio(cfg[CONV_LSB +: 2]);
  end
endmodule

// File: rtl/prescale_stage.sv
module prescale_stage #(
  parameter int W         = 4,
  parameter int RST_RATIO = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_en,
  input  logic [W-1:0] next_ratio,
  output logic         stb,
  output logic [W-1:0] cur_ratio
);
  logic [W-1:0] cnt;
  logic [W-1:0] act;
  logic         at_end;

  assign at_end    = (cnt == act - W'(1));
  assign stb       = up_en & at_end;
  assign cur_ratio = act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= W'(RST_RATIO);
    end else if (up_en) begin
      if (at_end) begin
        cnt <= '0;
        act <= next_ratio;
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/clk_prescale_chain.sv
module clk_prescale_chain
  import prescale_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_word,
  output logic        main_en,
  output logic        per1_en,
  output logic        per2_en,
  output logic        conv_en,
  output logic [9:0]  main_div,
  output logic [4:0]  per1_div,
  output logic [4:0]  per2_div,
  output logic [3:0]  conv_div
);
  logic [MAIN_W-1:0] main_r;
  logic [PER_W-1:0]  per1_r, per2_r;
  logic [CONV_W-1:0] conv_r;

  prescale_decode u_dec (
    .cfg(cfg_word), .main_r(main_r), .per1_r(per1_r),
    .per2_r(per2_r), .conv_r(conv_r)
  );

  prescale_stage #(.W(MAIN_W), .RST_RATIO(1)) u_main (
    .clk(clk), .rst_n(rst_n), .up_en(1'b1), .next_ratio(main_r),
    .stb(main_en), .cur_ratio(main_div)
  );

  prescale_stage #(.W(PER_W), .RST_RATIO(1)) u_per1 (
    .clk(clk), .rst_n(rst_n), .up_en(main_en), .next_ratio(per1_r),
    .stb(per1_en), .cur_ratio(per1_div)
  );

  prescale_stage #(.W(PER_W), .RST_RATIO(1)) u_per2 (
    .clk(clk), .rst_n(rst_n), .up_en(main_en), .next_ratio(per2_r),
    .stb(per2_en), .cur_ratio(per2_div)
  );

  prescale_stage #(.W(CONV_W), .RST_RATIO(2)) u_conv (
    .clk(clk), .rst_n(rst_n), .up_en(per2_en), .next_ratio(conv_r),
    .stb(conv_en), .cur_ratio(conv_div)
  );
endmodule

// File: rtl/clk_prescale_chain_chk.sv
module clk_prescale_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       main_en,
  input logic       per1_en,
  input logic       per2_en,
  input logic       conv_en,
  input logic [9:0] main_div,
  input logic [4:0] per1_div,
  input logic [4:0] per2_div,
  input logic [3:0] conv_div
);
  p_per1_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per1_en |-> main_en);
  p_per2_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per2_en |-> main_en);
  p_conv_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> per2_en);
  p_conv_no_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |=> !conv_en);
  p_main_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en |=> $stable(main_div));
  p_per1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !per1_en |=> $stable(per1_div));
  p_conv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> $stable(conv_div));
  p_main_pow2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(main_div) == 1);
endmodule

bind clk_prescale_chain clk_prescale_chain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .main_en(main_en), .per1_en(per1_en),
  .per2_en(per2_en), .conv_en(conv_en), .main_div(main_div),
  .per1_div(per1_div), .per2_div(per2_div), .conv_div(conv_div)
);

// File: tb/clk_prescale_chain_bench.sv
`timescale 1ns/1ps
module clk_prescale_chain_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        main_en, per1_en, per2_en, conv_en;
  logic [9:0]  main_div;
  logic [4:0]  per1_div, per2_div;
  logic [3:0]  conv_div;

  int n_checks = 0;
  int n_errs   = 0;
  int align_bad = 0;

  always #4 clk = ~clk;

  clk_prescale_chain u_clk_prescale_chain (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .main_en(main_en), .per1_en(per1_en), .per2_en(per2_en), .conv_en(conv_en),
    .main_div(main_div), .per1_div(per1_div), .per2_div(per2_div), .conv_div(conv_div)
  );

  localparam int MAIN_TBL [8] = '{2, 4, 8, 16, 64, 128, 256, 512};

  function automatic int exp_main(input int code);
    return (code < 8) ? 1 : MAIN_TBL[code - 8];
  endfunction
  function automatic int exp_per(input int code);
    return (code < 4) ? 1 : (2 ** (code - 3));
  endfunction
  function automatic int exp_conv(input int code);
    return 2 * code + 2;
  endfunction

  function automatic logic pick(input int sel);
    case (sel)
      0: return main_en;
      1: return per1_en;
      2: return per2_en;
      default: return conv_en;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  task automatic wait_stb(input int sel);
    do @(negedge clk); while (!pick(sel));
  endtask

  task automatic gap(input int sel, output int g);
    wait_stb(sel);
    g = 0;
    do begin @(negedge clk); g++; end while (!pick(sel));
  endtask

  task automatic settle();
    for (int k = 0; k < 3; k++) wait_stb(3);
  endtask

  function automatic logic [15:0] pack(input int m, input int p1, input int p2, input int c);
    return 16'((c << 14) | (p2 << 11) | (p1 << 8) | (m << 4));
  endfunction

  always @(negedge clk) begin
    if (rst_n && ((per1_en && !main_en) || (per2_en && !main_en) || (conv_en && !per2_en)))
      align_bad++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    n_checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    int g;
    int ph [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    chk("R8 main_div", main_div, 1);
    chk("R8 per1_div", per1_div, 1);
    chk("R8 per2_div", per2_div, 1);
    chk("R8 conv_div", conv_div, 2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 main_en", main_en, 1);
      chk("R8 per1_en", per1_en, 1);
      chk("R8 per2_en", per2_en, 1);
      ph[k] = conv_en;
    end
    chk("R8 conv alternates", ph[0] + ph[1], 1);
    chk("R8 conv alternates", ph[1] + ph[2], 1);
    chk("R8 conv alternates", ph[2] + ph[3], 1);

    // R1 sweep all main codes
    for (int m = 0; m < 16; m++) begin
      cfg_word = pack(m, 0, 0, 0);
      settle();
      chk("R1 main_div", main_div, exp_main(m));
      gap(0, g);
      chk("R1 main period", g, exp_main(m));
      gap(3, g);
      chk("R4 conv period", g, 2 * exp_main(m));
    end

    // R2, R3, R4 sweep peripheral and converter codes under main /2
    for (int i = 0; i < 8; i++) begin
      cfg_word = pack(8, i, 7 - i, i % 4);
      settle();
      chk("R2 per1_div", per1_div, exp_per(i));
      chk("R3 per2_div", per2_div, exp_per(7 - i));
      chk("R4 conv_div", conv_div, exp_conv(i % 4));
      gap(1, g);
      chk("R2 per1 period", g, 2 * exp_per(i));
      gap(2, g);
      chk("R3 per2 period", g, 2 * exp_per(7 - i));
      gap(3, g);
      chk("R4 conv period", g, 2 * exp_per(7 - i) * exp_conv(i % 4));
    end

    // R7 field independence via read-modify-write
    cfg_word = pack(9, 5, 6, 2);
    settle();
    cfg_word = (cfg_word & ~16'h00F0) | 16'h0080;
    settle();
    chk("R7 main_div", main_div, 2);
    chk("R7 per1_div", per1_div, 4);
    chk("R7 per2_div", per2_div, 8);
    chk("R7 conv_div", conv_div, 6);
    gap(1, g);
    chk("R7 per1 period", g, 8);
    cfg_word = (cfg_word & ~16'hC000) | 16'hC000;
    settle();
    chk("R7 main_div kept", main_div, 2);
    chk("R7 per1_div kept", per1_div, 4);
    chk("R7 per2_div kept", per2_div, 8);
    chk("R7 conv_div", conv_div, 8);
    gap(2, g);
    chk("R7 per2 period", g, 16);

    // R6 deferred change, no runt period
    cfg_word = pack(15, 0, 0, 0);
    settle();
    wait_stb(0);
    g = 0;
    repeat (10) begin @(negedge clk); g++; end
    cfg_word = pack(8, 0, 0, 0);
    @(negedge clk); g++;
    chk("R6 main_div held", main_div, 512);
    while (!main_en) begin @(negedge clk); g++; end
    chk("R6 old period kept", g, 512);
    @(negedge clk);
    chk("R6 main_div updated", main_div, 2);
    g = 1;
    while (!main_en) begin @(negedge clk); g++; end
    chk("R6 new period", g, 2);

    // R5 alignment monitor
    chk("R5 alignment violations", align_bad, 0);
    finish_run();
  end
endmodule